// File: doc/BRIEF.md
# Buffered Serial Port DMA Request Signalling

This block drives the two active-low DMA request lines of a buffered serial port: one that asks a DMA controller to drain the receiver and one that asks it to refill the transmitter. Its inputs are the occupancy counts of the receive and transmit queues, a one-cycle receive-timeout pulse, the queue-enable bit, the burst-mode select bit and a two-bit receive threshold code. The queues, the timeout counter and the DMA controller sit outside the block.

Two signalling styles exist. In single-transfer style each request line follows the presence of data directly. In burst style each line has hysteresis. The receive request asserts when the threshold is reached or a timeout arrives, and it releases only once the receiver is empty. The transmit request asserts when the transmit queue is empty and releases only once it is full. Burst style is in effect only when the queues are enabled and burst is selected. With the queues disabled, the port runs in character mode with a one-entry holding register, and single-transfer style applies whatever the select bit says.

Top module: `serdma_ready`

## Requirements
- R1: While `rst_n` is low both request outputs are high. After `rst_n` rises, both stay high through the next two rising clock edges. The first functional update happens on the third edge.
- R2: Burst style applies only when `fifo_on`=1 and `burst_sel`=1. When `fifo_on`=0, `burst_sel` has no effect and single-transfer style is used.
- R3: In single-transfer style, `rx_dreq_n` is low on the cycle after `rx_level`>=1 and high on the cycle after `rx_level`=0.
- R4: In single-transfer style, `tx_dreq_n` is low on the cycle after `tx_level`=0 and high on the cycle after `tx_level`>=1.
- R5: `trig_code` selects the receive threshold: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 14 characters.
- R6: In burst style, `rx_dreq_n` goes low on the cycle after `rx_level` reaches the selected threshold. It stays low while `rx_level` is nonzero, even when the level falls below the threshold.
- R7: In burst style, a `rx_tmo` pulse while `rx_level`>=1 drives `rx_dreq_n` low on the next cycle, even below the threshold.
- R8: In burst style, `rx_dreq_n` goes high only on the cycle after `rx_level`=0. An empty receiver wins over a simultaneous timeout.
- R9: In burst style, `tx_dreq_n` goes low on the cycle after `tx_level`=0 and high on the cycle after `tx_level` reaches the depth (16).
- R10: In burst style, `tx_dreq_n` keeps its value while 0 < `tx_level` < 16. It is low if the queue has not filled since it last emptied, and high otherwise.
- R11: Both outputs are registered. Every change in the inputs shows at the outputs exactly one clock later, never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_on | input | 1 | Queues enabled (0 = character mode) |
| burst_sel | input | 1 | Burst-style signalling select |
| trig_code | input | 2 | Receive threshold code |
| rx_level | input | 5 | Characters held in the receiver |
| tx_level | input | 5 | Characters held in the transmitter |
| rx_tmo | input | 1 | One-cycle receive timeout pulse |
| rx_dreq_n | output | 1 | Receive DMA request, active low |
| tx_dreq_n | output | 1 | Transmit DMA request, active low |

## Verification
The only state in this block is the hysteresis bit of each output. An error in that bit is hidden whenever the occupancy sits at an extreme, because there the next value is forced. It shows only in the band between release and assert thresholds, one cycle after the level enters that band. For this reason the stimulus walks each occupancy up and down through the band in both styles, for every threshold code. The outputs are then compared against a reference model on every clock, so a wrong hold or a wrong threshold is reported in the first cycle it affects.

// File: rtl/serdma_pkg.sv
package serdma_pkg;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_BURST  = 1'b1
  } dma_mode_e;

endpackage

// File: rtl/serdma_mode_dec.sv
module serdma_mode_dec
  import serdma_pkg::*;
(
  input  logic      fifo_on,
  input  logic      burst_sel,
  output dma_mode_e mode
);

  // Character mode forces single-transfer style (R2).
  always_comb begin
    if (fifo_on && burst_sel) begin
      mode = DMA_BURST;
    end else begin
      mode = DMA_SINGLE;
    end
  end

endmodule

// File: rtl/serdma_rx_ready.sv
module serdma_rx_ready
  import serdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dma_mode_e        mode,
  input  logic [1:0]       trig_code,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_tmo,
  output logic             rx_dreq_n
);

  localparam logic [CNT_W-1:0] LVL0 = CNT_W'(TRIG0);
  localparam logic [CNT_W-1:0] LVL1 = CNT_W'(TRIG1);
  localparam logic [CNT_W-1:0] LVL2 = CNT_W'(TRIG2);
  localparam logic [CNT_W-1:0] LVL3 = CNT_W'(TRIG3);

  logic [CNT_W-1:0] trig_lvl;
  logic             rx_empty;
  logic             rx_hit;
  logic             req_d;
  logic             req_q;
  logic             req_en;

  // Threshold decode (R5)
  always_comb begin
    unique case (trig_code)
      2'd0:    trig_lvl = LVL0;
      2'd1:    trig_lvl = LVL1;
      2'd2:    trig_lvl = LVL2;
      default: trig_lvl = LVL3;
    endcase
  end

  assign rx_empty = (rx_level == '0);
  assign rx_hit   = (rx_level >= trig_lvl) || rx_tmo;

  // Next state, active-high request inside
  always_comb begin
    req_d = req_q;
    if (mode == DMA_SINGLE) begin
      req_d = !rx_empty;
    end else if (rx_empty) begin
      req_d = 1'b0;
    end else if (rx_hit) begin
      req_d = 1'b1;
    end
  end

  assign req_en = (req_d != req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  assign rx_dreq_n = !req_q;

  assert_rx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_SINGLE && rx_level != '0) |=> !rx_dreq_n);

  assert_rx_trigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_BURST && rx_level >= trig_lvl) |=> !rx_dreq_n);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_BURST && rx_level != '0 && !rx_dreq_n) |=> !rx_dreq_n);

  assert_rx_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_BURST && rx_level != '0 && rx_tmo) |=> !rx_dreq_n);

  assert_rx_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |=> rx_dreq_n);

endmodule

// File: rtl/serdma_tx_ready.sv
module serdma_tx_ready
  import serdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dma_mode_e        mode,
  input  logic [CNT_W-1:0] tx_level,
  output logic             tx_dreq_n
);

  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic tx_empty;
  logic tx_full;
  logic req_d;
  logic req_q;
  logic req_en;

  assign tx_empty = (tx_level == '0);
  assign tx_full  = (tx_level >= FULL_LVL);

  always_comb begin
    req_d = req_q;
    if (mode == DMA_SINGLE) begin
      req_d = tx_empty;
    end else if (tx_empty) begin
      req_d = 1'b1;
    end else if (tx_full) begin
      req_d = 1'b0;
    end
  end

  assign req_en = (req_d != req_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_en) begin
      req_q <= req_d;
    end
  end

  assign tx_dreq_n = !req_q;

  assert_tx_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == '0) |=> !tx_dreq_n);

  assert_tx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_SINGLE && tx_level != '0) |=> tx_dreq_n);

  assert_tx_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_BURST && tx_level >= FULL_LVL) |=> tx_dreq_n);

  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DMA_BURST && tx_level != '0 && tx_dreq_n) |=> tx_dreq_n);

endmodule

// File: rtl/serdma_ready.sv
module serdma_ready
  import serdma_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CNT_W      = $clog2(DEPTH + 1),
  parameter int RST_STAGES = 2,
  parameter int TRIG0      = 1,
  parameter int TRIG1      = 4,
  parameter int TRIG2      = 8,
  parameter int TRIG3      = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic             burst_sel,
  input  logic [1:0]       trig_code,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             rx_tmo,
  output logic             rx_dreq_n,
  output logic             tx_dreq_n
);

  logic      rst_q;
  dma_mode_e mode;

  // Reset: asserted at once, released after RST_STAGES edges
  generate
    if (RST_STAGES <= 1) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= 1'b0;
        end else begin
          sync_q <= 1'b1;
        end
      end
      assign rst_q = sync_q;
    end else begin : g_syncn
      logic [RST_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
        end else begin
          sync_q <= {sync_q[RST_STAGES-2:0], 1'b1};
        end
      end
      assign rst_q = sync_q[RST_STAGES-1];
    end
  endgenerate

  serdma_mode_dec u_mode (
    .fifo_on   (fifo_on),
    .burst_sel (burst_sel),
    .mode      (mode)
  );

  serdma_rx_ready #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .TRIG0 (TRIG0),
    .TRIG1 (TRIG1),
    .TRIG2 (TRIG2),
    .TRIG3 (TRIG3)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_q),
    .mode      (mode),
    .trig_code (trig_code),
    .rx_level  (rx_level),
    .rx_tmo    (rx_tmo),
    .rx_dreq_n (rx_dreq_n)
  );

  serdma_tx_ready #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_q),
    .mode      (mode),
    .tx_level  (tx_level),
    .tx_dreq_n (tx_dreq_n)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> (rx_dreq_n && tx_dreq_n));

endmodule

// File: tb/sim_serdma_ready.sv
module sim_serdma_ready;

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk;
  logic             rst_n;
  logic             fifo_on;
  logic             burst_sel;
  logic [1:0]       trig_code;
  logic [CNT_W-1:0] rx_level;
  logic [CNT_W-1:0] tx_level;
  logic             rx_tmo;
  logic             rx_dreq_n;
  logic             tx_dreq_n;

  int    total;
  int    bad;
  bit    chk_on;
  string req;

  // reference model state
  int exp_rx;
  int exp_tx;
  int rel_cnt;

  serdma_ready u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_on   (fifo_on),
    .burst_sel (burst_sel),
    .trig_code (trig_code),
    .rx_level  (rx_level),
    .tx_level  (tx_level),
    .rx_tmo    (rx_tmo),
    .rx_dreq_n (rx_dreq_n),
    .tx_dreq_n (tx_dreq_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int thresh(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  // Behavioural model: integers, one update per edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_rx  <= 1;
      exp_tx  <= 1;
      rel_cnt <= 0;
    end else if (rel_cnt < 2) begin
      rel_cnt <= rel_cnt + 1;
    end else begin
      int rxl, txl;
      bit burst;
      rxl   = int'(rx_level);
      txl   = int'(tx_level);
      burst = fifo_on && burst_sel;
      if (!burst) begin
        exp_rx <= (rxl > 0) ? 0 : 1;
        exp_tx <= (txl == 0) ? 0 : 1;
      end else begin
        if (rxl == 0) exp_rx <= 1;
        else if (rxl >= thresh(int'(trig_code)) || rx_tmo) exp_rx <= 0;
        if (txl == 0) exp_tx <= 0;
        else if (txl >= DEPTH) exp_tx <= 1;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      total++;
      if (int'(rx_dreq_n) != exp_rx) begin
        bad++;
        $display("FAIL %s rx_dreq_n actual=%0d expected=%0d at %0t", req, rx_dreq_n, exp_rx, $time);
      end
      total++;
      if (int'(tx_dreq_n) != exp_tx) begin
        bad++;
        $display("FAIL %s tx_dreq_n actual=%0d expected=%0d at %0t", req, tx_dreq_n, exp_tx, $time);
      end
    end
  end

  task automatic step(input bit f, input bit b, input int tc, input int rl, input int tl, input bit tmo);
    @(negedge clk);
    fifo_on   = f;
    burst_sel = b;
    trig_code = 2'(tc);
    rx_level  = CNT_W'(rl);
    tx_level  = CNT_W'(tl);
    rx_tmo    = tmo;
  endtask

  task automatic sweep(input bit f, input bit b, input int tc);
    for (int i = 0; i <= DEPTH; i++) step(f, b, tc, i, i, 1'b0);
    for (int i = DEPTH; i >= 0; i--) step(f, b, tc, i, i, 1'b0);
    step(f, b, tc, 0, 0, 1'b0);
  endtask

  initial begin
    total = 0; bad = 0; chk_on = 1'b0; req = "R1";
    rst_n = 1'b1;
    fifo_on = 1'b0; burst_sel = 1'b0; trig_code = 2'd0;
    rx_level = '0; tx_level = '0; rx_tmo = 1'b0;
    #2 rst_n = 1'b0;
    chk_on = 1'b1;
    // R1: reset state and release latency
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b1, 1'b0, 0, 0, 0, 1'b0);

    // R3 R4: single-transfer sweeps
    req = "R3/R4";
    sweep(1'b1, 1'b0, 3);

    // R2: character mode ignores burst select
    req = "R2";
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 3, 1, 1, 1'b0);
      step(1'b0, 1'b1, 3, 0, 0, 1'b0);
      step(1'b0, 1'b1, 3, 1, 0, 1'b1);
    end
    step(1'b0, 1'b1, 3, 0, 0, 1'b0);

    // R5 R6 R9 R10: burst sweeps for every threshold
    for (int tc = 0; tc < 4; tc++) begin
      req = "R5/R6/R9/R10";
      sweep(1'b1, 1'b1, tc);
    end

    // R6: hold below threshold after reaching it
    req = "R6";
    step(1'b1, 1'b1, 2, 9, 5, 1'b0);
    step(1'b1, 1'b1, 2, 3, 5, 1'b0);
    step(1'b1, 1'b1, 2, 1, 5, 1'b0);
    step(1'b1, 1'b1, 2, 0, 5, 1'b0);
    step(1'b1, 1'b1, 2, 7, 5, 1'b0);

    // R7: timeout below threshold
    req = "R7";
    step(1'b1, 1'b1, 3, 2, 5, 1'b0);
    step(1'b1, 1'b1, 3, 2, 5, 1'b1);
    step(1'b1, 1'b1, 3, 2, 5, 1'b0);
    step(1'b1, 1'b1, 3, 1, 5, 1'b0);

    // R8: release only at empty, empty wins over timeout
    req = "R8";
    step(1'b1, 1'b1, 3, 0, 5, 1'b1);
    step(1'b1, 1'b1, 3, 0, 5, 1'b0);
    step(1'b1, 1'b1, 3, 13, 5, 1'b0);
    step(1'b1, 1'b1, 3, 0, 5, 1'b0);

    // R10: tx hold in band both ways
    req = "R10";
    step(1'b1, 1'b1, 0, 0, 0, 1'b0);
    step(1'b1, 1'b1, 0, 0, 15, 1'b0);
    step(1'b1, 1'b1, 0, 0, 16, 1'b0);
    step(1'b1, 1'b1, 0, 0, 1, 1'b0);
    step(1'b1, 1'b1, 0, 0, 8, 1'b0);

    // R11: input changes every cycle, compared one clock later
    req = "R11";
    begin
      int lf;
      lf = 32'h1d3a;
      for (int n = 0; n < 120; n++) begin
        lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
        step(lf[0] | lf[7], lf[1], (lf >> 2) & 3, (lf >> 4) % 17, (lf >> 9) % 17, lf[14] & lf[3]);
      end
    end
    step(1'b1, 1'b0, 0, 0, 0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    chk_on = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule